// File: doc/BRIEF.md
# Bad-Block Remapper with Spare Pool

This block translates logical flash block numbers into physical block numbers. A fixed group of physical blocks sits above the logical range and is never reached through a normal identity mapping. Those blocks act only as replacements. When the back-end reports that the physical block behind a logical block has failed, the remapper claims the next unused spare. It then asks an external copy engine to move the old contents onto that spare. It redirects the logical block only after the copy engine reports a clean finish.

Every host access is translated in the same cycle through a small content-addressed table with one entry per spare. A logical block with no live entry maps to itself. A failure that arrives during a migration is held in a one-deep slot and is served when the current migration ends. If the spare itself fails during its copy, that spare stays consumed and the next one is tried. When the pool is empty, the block becomes read-only for the rest of its life: reads are still translated and granted so that data can be recovered, while program and erase requests are refused until reset.

Top module: `bbr_remap`

## Requirements
- R1: After reset, spares_left equals NUM_SPARES, busy, cp_req and wr_locked are low, fail_ready is high, and every logical block translates to the same number.
- R2: Translation is combinational. acc_pblk follows acc_lblk in the same cycle, and a logical block without a live table entry maps to itself.
- R3: Spares are the physical blocks NUM_LOGICAL to NUM_LOGICAL+NUM_SPARES-1 and are claimed in ascending order. Serving a failure raises cp_req with cp_src set to the failed logical block's current physical block and cp_dst set to the claimed spare. spares_left decrements when a spare is claimed and never increases.
- R4: The table changes only on a cp_done without cp_bad. From then on the logical block translates to the spare. If a remapped block fails again, its copy starts from the spare it currently uses.
- R5: cp_req, cp_src and cp_dst hold steady until cp_done, and busy is high exactly while a copy request is open.
- R6: A failure accepted (fail_valid with fail_ready) while busy is held pending. fail_ready stays low while it is held, and its copy is requested after the current one ends.
- R7: cp_done with cp_bad consumes the destination spare and requests a new copy from the same source to the next spare. If no spare remains, the migration is dropped and the mapping is unchanged.
- R8: wr_locked rises the cycle after spares_left reaches zero and stays high until reset. Ops are encoded as 00 read, 01 program, 10 erase and 11 reserved. While wr_locked is high, any nonzero op is not granted, and reads are granted and translated.
- R9: A failure served when no spare is left starts no copy and leaves its translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access present |
| acc_op | input | 2 | Access kind: 00 read, 01 program, 10 erase, 11 reserved |
| acc_lblk | input | LBLK_W | Logical block of the access |
| acc_pblk | output | PBLK_W | Translated physical block |
| acc_grant | output | 1 | Access allowed |
| fail_valid | input | 1 | Back-end reports a failed block |
| fail_lblk | input | LBLK_W | Logical block whose physical block failed |
| fail_ready | output | 1 | Pending slot is free |
| cp_req | output | 1 | Copy request open |
| cp_src | output | PBLK_W | Copy source physical block |
| cp_dst | output | PBLK_W | Copy destination spare |
| cp_done | input | 1 | Copy engine finished (one-cycle pulse) |
| cp_bad | input | 1 | With cp_done: the destination failed |
| spares_left | output | CNT_W | Unclaimed spares |
| busy | output | 1 | Migration in progress |
| wr_locked | output | 1 | Sticky read-only flag |

## Verification
The bench builds the block with NUM_LOGICAL=64 and NUM_SPARES=5, so the spares are physical blocks 64 to 68. With a pool this small, a few directed failures can reach every situation: a block that is remapped twice, a failure queued behind a running copy, a spare that fails during its own copy, and pool exhaustion with the lock that follows it. Once the pool is empty, one more failure shows that the block starts no copy and leaves the mapping unchanged.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_RSVD  = 2'b11
   } bbr_op_e;

   typedef enum logic {
      MG_IDLE = 1'b0,
      MG_COPY = 1'b1
   } mg_state_e;
endpackage

// File: rtl/bbr_remap_cam.sv
module bbr_remap_cam #(
   parameter int LBLK_W     = 10,
   parameter int PBLK_W     = 11,
   parameter int ENTRIES    = 16,
   parameter int SPARE_BASE = 1024,
   parameter int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LBLK_W-1:0] a_lblk,
   output logic [PBLK_W-1:0] a_pblk,
   input  logic [LBLK_W-1:0] b_lblk,
   output logic [PBLK_W-1:0] b_pblk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LBLK_W-1:0] wr_lblk
);
   logic [ENTRIES-1:0] ent_v;
   logic [LBLK_W-1:0]  ent_l [ENTRIES];
   logic [ENTRIES-1:0] hit_a, hit_b, hit_w;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign hit_a[g] = ent_v[g] && (ent_l[g] == a_lblk);
      assign hit_b[g] = ent_v[g] && (ent_l[g] == b_lblk);
      assign hit_w[g] = ent_v[g] && (ent_l[g] == wr_lblk);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_v[g] <= 1'b0;
            ent_l[g] <= '0;
         end else if (wr_en) begin
            if (wr_idx == IDX_W'(g)) begin
               ent_v[g] <= 1'b1;
               ent_l[g] <= wr_lblk;
            end else if (hit_w[g]) begin
               ent_v[g] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      a_pblk = PBLK_W'(a_lblk);
      b_pblk = PBLK_W'(b_lblk);
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_a[i]) a_pblk = PBLK_W'(SPARE_BASE + i);
         if (hit_b[i]) b_pblk = PBLK_W'(SPARE_BASE + i);
      end
   end
endmodule

// File: rtl/bbr_spare_alloc.sv
module bbr_spare_alloc #(
   parameter int NUM_SPARES = 16,
   parameter int IDX_W      = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1,
   parameter int CNT_W      = $clog2(NUM_SPARES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic             avail,
   output logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] left,
   output logic             locked
);
   logic [CNT_W-1:0] ptr;

   assign avail = (ptr < CNT_W'(NUM_SPARES));
   assign idx   = IDX_W'(ptr);
   assign left  = CNT_W'(NUM_SPARES) - ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr    <= '0;
         locked <= 1'b0;
      end else begin
         if (take && avail) ptr <= ptr + 1'b1;
         if (left == '0) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/bbr_migrate_ctrl.sv
module bbr_migrate_ctrl
   import bbr_pkg::*;
#(
   parameter int LBLK_W     = 10,
   parameter int PBLK_W     = 11,
   parameter int IDX_W      = 4,
   parameter int SPARE_BASE = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fail_valid,
   input  logic [LBLK_W-1:0] fail_lblk,
   output logic              fail_ready,
   output logic [LBLK_W-1:0] lk_lblk,
   input  logic [PBLK_W-1:0] lk_pblk,
   input  logic              alloc_avail,
   input  logic [IDX_W-1:0]  alloc_idx,
   output logic              alloc_take,
   output logic              cp_req,
   output logic [PBLK_W-1:0] cp_src,
   output logic [PBLK_W-1:0] cp_dst,
   input  logic              cp_done,
   input  logic              cp_bad,
   output logic              map_wr_en,
   output logic [IDX_W-1:0]  map_wr_idx,
   output logic [LBLK_W-1:0] map_wr_lblk,
   output logic              busy
);
   mg_state_e         st;
   logic              pend_v;
   logic [LBLK_W-1:0] pend_l;
   logic [LBLK_W-1:0] cur_l;
   logic [PBLK_W-1:0] cur_src;
   logic [IDX_W-1:0]  cur_idx;

   assign fail_ready  = !pend_v;
   assign lk_lblk     = pend_l;
   assign busy        = (st == MG_COPY);
   assign cp_req      = busy;
   assign cp_src      = cur_src;
   assign cp_dst      = PBLK_W'(SPARE_BASE) + PBLK_W'(cur_idx);
   assign map_wr_en   = busy && cp_done && !cp_bad;
   assign map_wr_idx  = cur_idx;
   assign map_wr_lblk = cur_l;
   assign alloc_take  = alloc_avail &&
                        (((st == MG_IDLE) && pend_v) || (busy && cp_done && cp_bad));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= MG_IDLE;
         pend_v  <= 1'b0;
         pend_l  <= '0;
         cur_l   <= '0;
         cur_src <= '0;
         cur_idx <= '0;
      end else begin
         case (st)
            MG_IDLE: if (pend_v) begin
               pend_v <= 1'b0;
               if (alloc_avail) begin
                  st      <= MG_COPY;
                  cur_l   <= pend_l;
                  cur_src <= lk_pblk;
                  cur_idx <= alloc_idx;
               end
            end
            MG_COPY: if (cp_done) begin
               if (cp_bad && alloc_avail) cur_idx <= alloc_idx;
               else                       st      <= MG_IDLE;
            end
            default: st <= MG_IDLE;
         endcase
         if (fail_valid && fail_ready) begin
            pend_v <= 1'b1;
            pend_l <= fail_lblk;
         end
      end
   end
endmodule

// File: rtl/bbr_remap.sv
module bbr_remap
   import bbr_pkg::*;
#(
   parameter int NUM_LOGICAL = 1024,
   parameter int NUM_SPARES  = 16,
   parameter int LBLK_W      = $clog2(NUM_LOGICAL),
   parameter int PBLK_W      = $clog2(NUM_LOGICAL + NUM_SPARES),
   parameter int CNT_W       = $clog2(NUM_SPARES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_op,
   input  logic [LBLK_W-1:0] acc_lblk,
   output logic [PBLK_W-1:0] acc_pblk,
   output logic              acc_grant,
   input  logic              fail_valid,
   input  logic [LBLK_W-1:0] fail_lblk,
   output logic              fail_ready,
   output logic              cp_req,
   output logic [PBLK_W-1:0] cp_src,
   output logic [PBLK_W-1:0] cp_dst,
   input  logic              cp_done,
   input  logic              cp_bad,
   output logic [CNT_W-1:0]  spares_left,
   output logic              busy,
   output logic              wr_locked
);
   localparam int IDX_W      = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1;
   localparam int SPARE_BASE = NUM_LOGICAL;

   if (NUM_SPARES < 1 || NUM_SPARES > 64) begin : g_bad_spares
      $error("bbr_remap: NUM_SPARES must lie in 1..64");
   end
   if (NUM_LOGICAL < 2) begin : g_bad_logical
      $error("bbr_remap: NUM_LOGICAL must be at least 2");
   end

   logic [LBLK_W-1:0] lk_lblk;
   logic [PBLK_W-1:0] lk_pblk;
   logic              al_avail, al_take;
   logic [IDX_W-1:0]  al_idx;
   logic              mw_en;
   logic [IDX_W-1:0]  mw_idx;
   logic [LBLK_W-1:0] mw_lblk;

   bbr_remap_cam #(
      .LBLK_W(LBLK_W), .PBLK_W(PBLK_W), .ENTRIES(NUM_SPARES),
      .SPARE_BASE(SPARE_BASE), .IDX_W(IDX_W)
   ) u_cam (
      .clk(clk), .rst_n(rst_n),
      .a_lblk(acc_lblk), .a_pblk(acc_pblk),
      .b_lblk(lk_lblk), .b_pblk(lk_pblk),
      .wr_en(mw_en), .wr_idx(mw_idx), .wr_lblk(mw_lblk)
   );

   bbr_spare_alloc #(
      .NUM_SPARES(NUM_SPARES), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .take(al_take),
      .avail(al_avail), .idx(al_idx), .left(spares_left), .locked(wr_locked)
   );

   bbr_migrate_ctrl #(
      .LBLK_W(LBLK_W), .PBLK_W(PBLK_W), .IDX_W(IDX_W), .SPARE_BASE(SPARE_BASE)
   ) u_mig (
      .clk(clk), .rst_n(rst_n),
      .fail_valid(fail_valid), .fail_lblk(fail_lblk), .fail_ready(fail_ready),
      .lk_lblk(lk_lblk), .lk_pblk(lk_pblk),
      .alloc_avail(al_avail), .alloc_idx(al_idx), .alloc_take(al_take),
      .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst),
      .cp_done(cp_done), .cp_bad(cp_bad),
      .map_wr_en(mw_en), .map_wr_idx(mw_idx), .map_wr_lblk(mw_lblk),
      .busy(busy)
   );

   assign acc_grant = acc_valid && ((acc_op == OP_READ) || !wr_locked);
endmodule

// File: rtl/bbr_remap_chk.sv
module bbr_remap_chk #(
   parameter int PBLK_W = 11,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_op,
   input logic              acc_grant,
   input logic              fail_valid,
   input logic              fail_ready,
   input logic              cp_req,
   input logic [PBLK_W-1:0] cp_src,
   input logic [PBLK_W-1:0] cp_dst,
   input logic              cp_done,
   input logic [CNT_W-1:0]  spares_left,
   input logic              wr_locked
);
   a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      cp_req && !cp_done |=> cp_req && $stable(cp_src) && $stable(cp_dst));

   a_r3_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> spares_left <= $past(spares_left));

   a_r6_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && fail_ready && cp_req && !cp_done |=> !fail_ready);

   a_r8_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
      spares_left == '0 |=> wr_locked);

   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wr_locked |=> wr_locked);

   a_r8_no_modify: assert property (@(posedge clk) disable iff (!rst_n)
      wr_locked && acc_op != 2'b00 |-> !acc_grant);

   a_r8_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_op == 2'b00 |-> acc_grant);
endmodule

bind bbr_remap bbr_remap_chk #(.PBLK_W(PBLK_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
   .acc_grant(acc_grant), .fail_valid(fail_valid), .fail_ready(fail_ready),
   .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst), .cp_done(cp_done),
   .spares_left(spares_left), .wr_locked(wr_locked)
);

// File: tb/tb_bbr_remap.sv
`timescale 1ns/1ps
module tb_bbr_remap;
   localparam int NL = 64;
   localparam int NS = 5;
   localparam int LW = $clog2(NL);
   localparam int PW = $clog2(NL + NS);
   localparam int CW = $clog2(NS + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [1:0]    acc_op = 2'b00;
   logic [LW-1:0] acc_lblk = '0;
   logic [PW-1:0] acc_pblk;
   logic          acc_grant;
   logic          fail_valid = 1'b0;
   logic [LW-1:0] fail_lblk = '0;
   logic          fail_ready;
   logic          cp_req;
   logic [PW-1:0] cp_src, cp_dst;
   logic          cp_done = 1'b0;
   logic          cp_bad = 1'b0;
   logic [CW-1:0] spares_left;
   logic          busy, wr_locked;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bbr_remap #(.NUM_LOGICAL(NL), .NUM_SPARES(NS)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
      .acc_lblk(acc_lblk), .acc_pblk(acc_pblk), .acc_grant(acc_grant),
      .fail_valid(fail_valid), .fail_lblk(fail_lblk), .fail_ready(fail_ready),
      .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst),
      .cp_done(cp_done), .cp_bad(cp_bad), .spares_left(spares_left),
      .busy(busy), .wr_locked(wr_locked)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic xlate(input string req, input int lblk, input int exp);
      acc_lblk = LW'(lblk);
      #1;
      chk(req, $sformatf("translate %0d", lblk), int'(acc_pblk), exp);
   endtask

   task automatic report_fail(input int lblk);
      @(negedge clk);
      fail_valid = 1'b1;
      fail_lblk  = LW'(lblk);
      @(negedge clk);
      fail_valid = 1'b0;
   endtask

   task automatic expect_copy(input string req, input int src, input int dst);
      int n = 0;
      while (!cp_req && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(req, "cp_req", int'(cp_req), 1);
      chk(req, "busy", int'(busy), 1);
      chk(req, "cp_src", int'(cp_src), src);
      chk(req, "cp_dst", int'(cp_dst), dst);
   endtask

   task automatic finish_copy(input logic bad);
      @(negedge clk);
      cp_done = 1'b1;
      cp_bad  = bad;
      @(negedge clk);
      cp_done = 1'b0;
      cp_bad  = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "spares_left", int'(spares_left), NS);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "cp_req", int'(cp_req), 0);
      chk("R1", "wr_locked", int'(wr_locked), 0);
      chk("R1", "fail_ready", int'(fail_ready), 1);
      xlate("R1", 0, 0);
      xlate("R2", 63, 63);
      acc_valid = 1'b1; acc_op = 2'b01; #1;
      chk("R8", "program grant unlocked", int'(acc_grant), 1);
      acc_op = 2'b00;
   endtask

   task automatic t_first_remap;
      report_fail(5);
      expect_copy("R3", 5, 64);
      chk("R3", "spares_left after claim", int'(spares_left), 4);
      repeat (3) @(negedge clk);
      chk("R5", "request held", int'(cp_dst), 64);
      xlate("R4", 5, 5);
      finish_copy(1'b0);
      chk("R5", "busy after done", int'(busy), 0);
      xlate("R4", 5, 64);
      xlate("R2", 6, 6);
   endtask

   task automatic t_second_remap;
      report_fail(5);
      expect_copy("R4", 64, 65);
      finish_copy(1'b0);
      xlate("R4", 5, 65);
   endtask

   task automatic t_pending_and_bad_spare;
      report_fail(10);
      expect_copy("R3", 10, 66);
      chk("R6", "fail_ready before", int'(fail_ready), 1);
      report_fail(20);
      chk("R6", "fail_ready while held", int'(fail_ready), 0);
      chk("R6", "first copy still open", int'(cp_dst), 66);
      finish_copy(1'b0);
      xlate("R4", 10, 66);
      expect_copy("R6", 20, 67);
      chk("R6", "slot freed", int'(fail_ready), 1);
      finish_copy(1'b1);
      expect_copy("R7", 20, 68);
      xlate("R7", 20, 20);
      chk("R7", "spares_left", int'(spares_left), 0);
      finish_copy(1'b0);
      xlate("R7", 20, 68);
   endtask

   task automatic t_lock;
      @(negedge clk);
      chk("R8", "wr_locked", int'(wr_locked), 1);
      acc_valid = 1'b1;
      acc_op = 2'b01; acc_lblk = LW'(10); #1;
      chk("R8", "program refused", int'(acc_grant), 0);
      acc_op = 2'b10; #1;
      chk("R8", "erase refused", int'(acc_grant), 0);
      acc_op = 2'b00; #1;
      chk("R8", "read granted", int'(acc_grant), 1);
      chk("R8", "read translated", int'(acc_pblk), 66);
      report_fail(30);
      repeat (6) begin
         @(negedge clk);
         if (cp_req) chk("R9", "no copy when empty", 1, 0);
      end
      chk("R9", "cp_req", int'(cp_req), 0);
      xlate("R9", 30, 30);
      chk("R9", "fail_ready", int'(fail_ready), 1);
      chk("R8", "still locked", int'(wr_locked), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_remap();
      t_second_remap();
      t_pending_and_bad_spare();
      t_lock();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule